// File: doc/BRIEF.md
# Mode-Multiplexed Output Port

This block is an 8-bit, output-only port whose pins have two possible owners. In single-chip and bootstrap operation the pins carry a data latch that software loads through a small register interface. In expanded and special-test operation the same pins carry the low byte of the external bus address. The block has no direction register, because every pin is always an output.

The data latch accepts writes in every mode, including while the address bus owns the pins. Software can therefore preload a value before it switches from expanded to single-chip operation. A read returns whatever is presented to the pin drivers, not the latch contents. In expanded modes a read returns the current address low byte.

Top module: `opm_port`

## Requirements
- R1: When reset is high on a clock edge, the data latch returns to 0x00. In mode 00 the pins then read 0x00 from the first cycle after reset is released.
- R2: With mode 00 (single-chip) or mode 10 (bootstrap), `pin_out` equals the data latch contents.
- R3: With mode 01 (expanded) or mode 11 (special test), `pin_out` equals `addr_lo`. Bit 0 of the mode code alone selects the address path.
- R4: A write occurs when `wr_en` is high and `reg_addr` equals the `PORT_ADDR` parameter (default 6'h05) at a clock edge. The write loads `wr_data` into the latch, and in modes 00 and 10 the new value is on `pin_out` in the following cycle.
- R5: A write strobe while `reg_addr` differs from `PORT_ADDR` leaves the latch, and therefore the pins, unchanged.
- R6: A write made while in mode 01 or 11 is still stored in the latch. It leaves the pins on the address and becomes visible once the mode changes to 00 or 10.
- R7: `rd_data` always equals the level driven to the pins. In modes 01 and 11 it therefore returns `addr_lo`, not the latch.
- R8: With `wr_en` low, a matching `reg_addr` and any `wr_data` leave the latch unchanged.
- R9: Changes of `mode` and of `addr_lo` reach `pin_out` within the same cycle, with no register on the way.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| mode | input | 2 | Operating mode: 00 single-chip, 01 expanded, 10 bootstrap, 11 special test |
| addr_lo | input | W | Low byte of the external bus address |
| reg_addr | input | REG_AW | Register address for the write decode |
| wr_en | input | 1 | Write strobe |
| wr_data | input | W | Data to load into the latch |
| rd_data | output | W | Read-back of the pin driver level |
| pin_out | output | W | Pin driver outputs |

## Verification
The hardest case to reach is a latch write whose effect cannot be seen when it happens, because the address bus owns the pins at that moment. The bench writes a value in expanded mode while keeping the address low byte different from the written data. It first confirms that the pins and the read-back still follow the address. It then switches to single-chip mode and expects the stored value on the pins in that same cycle. A reset applied while the latch holds a non-zero value is also covered, so the return to 0x00 is visible.

// File: rtl/opm_port.sv
package opm_pkg;
  typedef enum logic [1:0] {
    MODE_SINGLE = 2'b00,
    MODE_EXPAND = 2'b01,
    MODE_BOOT   = 2'b10,
    MODE_TEST   = 2'b11
  } opm_mode_e;

  // Bit 0 of the mode code hands the pins to the address bus
  function automatic logic addr_owns(input logic [1:0] m);
    return m[0];
  endfunction
endpackage

module opm_decode #(
  parameter int REG_AW = 6,
  parameter logic [REG_AW-1:0] PORT_ADDR = 6'h05
) (
  input  logic [REG_AW-1:0] reg_addr,
  input  logic              wr_en,
  output logic              hit_we
);
  always_comb hit_we = wr_en && (reg_addr == PORT_ADDR);
endmodule

module opm_latch #(
  parameter int W = 8,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [W-1:0] din,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= RST_VAL;
    else if (we) q <= din;
  end
endmodule

module opm_pinmux #(
  parameter int W = 8
) (
  input  logic [1:0]   mode,
  input  logic [W-1:0] latch_q,
  input  logic [W-1:0] addr_lo,
  output logic [W-1:0] drv
);
  import opm_pkg::*;
  always_comb drv = addr_owns(mode) ? addr_lo : latch_q;
endmodule

module opm_port #(
  parameter int W = 8,
  parameter int REG_AW = 6,
  parameter logic [REG_AW-1:0] PORT_ADDR = 6'h05,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        mode,
  input  logic [W-1:0]      addr_lo,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic              wr_en,
  input  logic [W-1:0]      wr_data,
  output logic [W-1:0]      rd_data,
  output logic [W-1:0]      pin_out
);
  logic         hit_we;
  logic [W-1:0] latch_q;
  logic [W-1:0] drv;

  opm_decode #(.REG_AW(REG_AW), .PORT_ADDR(PORT_ADDR)) u_dec (
    .reg_addr(reg_addr), .wr_en(wr_en), .hit_we(hit_we)
  );

  opm_latch #(.W(W), .RST_VAL(RST_VAL)) u_latch (
    .clk(clk), .rst(rst), .we(hit_we), .din(wr_data), .q(latch_q)
  );

  opm_pinmux #(.W(W)) u_mux (
    .mode(mode), .latch_q(latch_q), .addr_lo(addr_lo), .drv(drv)
  );

  assign pin_out = drv;
  assign rd_data = drv;
endmodule

// File: rtl/opm_port_chk.sv
module opm_port_chk #(
  parameter int W = 8,
  parameter int REG_AW = 6,
  parameter logic [REG_AW-1:0] PORT_ADDR = 6'h05,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        mode,
  input logic [W-1:0]      addr_lo,
  input logic [REG_AW-1:0] reg_addr,
  input logic              wr_en,
  input logic [W-1:0]      wr_data,
  input logic [W-1:0]      rd_data,
  input logic [W-1:0]      pin_out
);
  logic rst_q;
  always_ff @(posedge clk) rst_q <= rst;

  wire hit = wr_en && (reg_addr == PORT_ADDR);

  assert_rst_value_R1: assert property (@(posedge clk) disable iff (rst)
    (rst_q === 1'b1 && !mode[0]) |-> pin_out == RST_VAL);

  assert_addr_path_R3: assert property (@(posedge clk) disable iff (rst)
    mode[0] |-> pin_out == addr_lo);

  assert_write_lands_R4: assert property (@(posedge clk) disable iff (rst)
    hit |=> (mode[0] || pin_out == $past(wr_data)));

  assert_hold_no_write_R5: assert property (@(posedge clk) disable iff (rst)
    (!hit && !mode[0]) |=> (mode[0] || pin_out == $past(pin_out)));

  assert_read_addr_R7: assert property (@(posedge clk) disable iff (rst)
    mode[0] |-> rd_data == addr_lo);

  assert_read_pins_R7: assert property (@(posedge clk) disable iff (rst)
    rd_data == pin_out);
endmodule

bind opm_port opm_port_chk #(
  .W(W), .REG_AW(REG_AW), .PORT_ADDR(PORT_ADDR), .RST_VAL(RST_VAL)
) u_chk (
  .clk(clk), .rst(rst), .mode(mode), .addr_lo(addr_lo), .reg_addr(reg_addr),
  .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .pin_out(pin_out)
);

// File: tb/test_opm_port.sv
module test_opm_port;
  import opm_pkg::*;

  localparam int W = 8;
  localparam int REG_AW = 6;
  localparam logic [REG_AW-1:0] PADDR = 6'h05;

  logic              clk = 1'b0;
  logic              rst;
  logic [1:0]        mode;
  logic [W-1:0]      addr_lo;
  logic [REG_AW-1:0] reg_addr;
  logic              wr_en;
  logic [W-1:0]      wr_data;
  logic [W-1:0]      rd_data;
  logic [W-1:0]      pin_out;

  int tests = 0;
  int fails = 0;
  logic [W-1:0] exp_latch;

  always #2 clk = ~clk;

  opm_port i_opm_port (
    .clk(clk), .rst(rst), .mode(mode), .addr_lo(addr_lo), .reg_addr(reg_addr),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .pin_out(pin_out)
  );

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [REG_AW-1:0] a, input logic [W-1:0] d, input logic en);
    @(negedge clk);
    reg_addr = a; wr_data = d; wr_en = en;
    @(negedge clk);
    wr_en = 1'b0; reg_addr = '0; wr_data = 8'hFF;
    #1;
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst = 1'b1; mode = MODE_SINGLE;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    exp_latch = 8'h00;
    #1;
    check("R1 pins after reset", pin_out, 8'h00);
    check("R1 read after reset", rd_data, 8'h00);
  endtask

  task automatic t_single();
    mode = MODE_SINGLE;
    do_write(PADDR, 8'hA5, 1'b1);
    exp_latch = 8'hA5;
    check("R4 single-chip write on pins", pin_out, exp_latch);
    check("R2 single-chip pins show latch", pin_out, exp_latch);
    check("R7 read returns pin level", rd_data, exp_latch);
  endtask

  task automatic t_boot();
    @(negedge clk);
    mode = MODE_BOOT; addr_lo = 8'h77;
    #1;
    check("R2 bootstrap pins show latch", pin_out, exp_latch);
    do_write(PADDR, 8'h3C, 1'b1);
    exp_latch = 8'h3C;
    check("R4 bootstrap write on pins", pin_out, exp_latch);
  endtask

  task automatic t_expanded();
    @(negedge clk);
    mode = MODE_EXPAND; addr_lo = 8'h34;
    #1;
    check("R3 expanded pins show address", pin_out, 8'h34);
    check("R7 expanded read returns address", rd_data, 8'h34);
    addr_lo = 8'hEF;
    #1;
    check("R9 address change same cycle", pin_out, 8'hEF);
    mode = MODE_TEST;
    #1;
    check("R3 test mode pins show address", pin_out, 8'hEF);
  endtask

  task automatic t_write_hidden();
    @(negedge clk);
    mode = MODE_EXPAND; addr_lo = 8'h11;
    do_write(PADDR, 8'h5A, 1'b1);
    exp_latch = 8'h5A;
    check("R6 pins stay on address during write", pin_out, 8'h11);
    check("R7 read stays on address", rd_data, 8'h11);
    mode = MODE_SINGLE;
    #1;
    check("R6 stored value appears after switch", pin_out, exp_latch);
    check("R9 mode switch same cycle", rd_data, exp_latch);
  endtask

  task automatic t_ignored();
    mode = MODE_SINGLE;
    do_write(6'h04, 8'hC3, 1'b1);
    check("R5 wrong address ignored", pin_out, exp_latch);
    do_write(6'h25, 8'h96, 1'b1);
    check("R5 wrong address high bit ignored", pin_out, exp_latch);
    do_write(PADDR, 8'h81, 1'b0);
    check("R8 strobe low ignored", pin_out, exp_latch);
  endtask

  task automatic t_reset_mid();
    check("R1 latch nonzero before reset", pin_out, 8'h5A);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    exp_latch = 8'h00;
    #1;
    check("R1 reset clears loaded latch", pin_out, exp_latch);
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    #400000;
    tests++; fails++;
    $display("FAIL watchdog all requirements actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    rst = 1'b1; mode = MODE_SINGLE; addr_lo = '0; reg_addr = '0;
    wr_en = 1'b0; wr_data = '0; exp_latch = '0;
    t_reset();
    t_single();
    t_boot();
    t_expanded();
    t_write_hidden();
    t_ignored();
    t_reset_mid();
    repeat (2) @(negedge clk);
    summary();
    $finish;
  end
endmodule